// File: doc/BRIEF.md
# Temperature-Indexed Table Lookup

This block turns a signed temperature sample into a row number for one of two temperature tables and returns the byte stored in that row. The fine table has one row for every 2°C, starting at -40°C and ending with the row that begins at +102°C, so it has 72 rows. The coarse table has 36 rows, each covering 4°C, and its last row starts at +100°C. In both tables row 0 starts at -40°C. A reading colder than -40°C selects row 0. A reading past the top of the range selects the last row. A loop that sets modulation, bias, power set point or a PWM reference uses the block to follow temperature, with the table contents chosen per device.

The temperature arrives as a signed 16-bit value in units of 1/256°C, together with a one-cycle sample strobe. A mode input sets which table the sample uses. The row number is the temperature plus 40°C, divided by the step and rounded down. The outputs change only when a sample passes through, and keep their values between samples. A simple write port loads either table before use.

Top module: `temp_lut_indexer`

## Requirements
- R1: After reset, lut_valid, lut_index and lut_data are all 0.
- R2: For every cycle in which samp_valid is 1, lut_valid is 1 for exactly one cycle, two clock edges later. Samples in back-to-back cycles give lut_valid in back-to-back cycles.
- R3: Fine mode (coarse_mode = 0): lut_index = floor((temp_in/256 + 40) / 2) for temperatures from -40°C up to the top of the 72-row range.
- R4: Coarse mode (coarse_mode = 1): lut_index = floor((temp_in/256 + 40) / 4) for temperatures from -40°C up to the top of the 36-row range.
- R5: A temperature below -40°C (temp_in < -10240) gives lut_index 0 in both modes.
- R6: A temperature beyond the range gives lut_index 71 in fine mode and 35 in coarse mode. This includes the largest input code, 32767.
- R7: lut_data equals the entry at row lut_index of the table the sample selected. That is the fine table for mode 0 and the coarse table for mode 1.
- R8: In a cycle where lut_valid is 0, lut_index and lut_data keep their previous values.
- R9: The mode is captured with samp_valid. A change of coarse_mode in the cycles after a sample does not affect that sample's result.
- R10: A write with tbl_we = 1 stores tbl_wdata at row tbl_addr of the coarse table if tbl_coarse = 1, and of the fine table otherwise. A write to a row at or beyond that table's size (72 fine, 36 coarse) changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 1 | One-cycle strobe marking a new temperature sample |
| temp_in | input | 16 | Signed temperature, 1/256°C per LSB |
| coarse_mode | input | 1 | 0 selects the 2°C table, 1 selects the 4°C table |
| tbl_we | input | 1 | Table write enable |
| tbl_coarse | input | 1 | Write target: 0 fine table, 1 coarse table |
| tbl_addr | input | 7 | Row to write |
| tbl_wdata | input | 8 | Byte to write |
| lut_valid | output | 1 | One-cycle strobe for a new result |
| lut_index | output | 7 | Row selected for the latest sample |
| lut_data | output | 8 | Table entry at that row |

## Verification
The hardest cases to reach from the ports are the edges of the step arithmetic. These are a code one LSB on either side of -40°C, a code just below and exactly on a row boundary, and the two clamped ends. Cases that stress the capture stage are also hard to reach: back-to-back samples whose modes alternate, so that each stage holds a different mode. The stimulus places exact codes at each boundary. It sweeps every row of both tables with a small offset into the row. It issues consecutive samples with the mode switched on every cycle. Beforehand it writes sentinel bytes to out-of-range rows, so that any aliasing shows up in the last and first rows.

// File: rtl/temp_lut_pkg.sv
package temp_lut_pkg;

  // Row number for a reading: (t + base) >> (frac + shift), floored at 0
  // and capped at max_idx.
  function automatic int unsigned lut_index_of(input int signed t_raw,
                                               input int unsigned frac_w,
                                               input int unsigned base_c,
                                               input int unsigned shift,
                                               input int unsigned max_idx);
    int signed   off;
    int unsigned q;
    off = t_raw + $signed(base_c << frac_w);
    if (off < 0) return 0;
    q = unsigned'(off) >> (frac_w + shift);
    if (q > max_idx) q = max_idx;
    return q;
  endfunction

  // True when the reading is colder than the first row's start.
  function automatic logic below_floor(input int signed t_raw,
                                       input int unsigned frac_w,
                                       input int unsigned base_c);
    return t_raw < -$signed(base_c << frac_w);
  endfunction

endpackage

// File: rtl/temp_index_calc.sv
module temp_index_calc
  import temp_lut_pkg::*;
#(
  parameter int TEMP_W       = 16,
  parameter int FRAC_W       = 8,
  parameter int BASE_C       = 40,
  parameter int FINE_SHIFT   = 1,
  parameter int COARSE_SHIFT = 2,
  parameter int FINE_DEPTH   = 72,
  parameter int COARSE_DEPTH = 36,
  parameter int IDX_W        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              coarse_mode,
  output logic              s1_valid,
  output logic              s1_coarse,
  output logic [IDX_W-1:0]  s1_idx
);

  logic signed [TEMP_W-1:0] temp_s;
  int signed                temp_int;
  logic [IDX_W-1:0]         idx_fine;
  logic [IDX_W-1:0]         idx_coarse;
  logic                     below_range;  // event wire for checks

  assign temp_s   = temp_in;
  assign temp_int = int'(temp_s);

  always_comb begin
    idx_fine   = IDX_W'(lut_index_of(temp_int, FRAC_W, BASE_C, FINE_SHIFT,
                                     FINE_DEPTH - 1));
    idx_coarse = IDX_W'(lut_index_of(temp_int, FRAC_W, BASE_C, COARSE_SHIFT,
                                     COARSE_DEPTH - 1));
  end

  assign below_range = below_floor(temp_int, FRAC_W, BASE_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_coarse <= 1'b0;
      s1_idx    <= '0;
    end else begin
      s1_valid <= samp_valid;
      if (samp_valid) begin
        s1_coarse <= coarse_mode;
        s1_idx    <= coarse_mode ? idx_coarse : idx_fine;
      end
    end
  end

  // R5: a reading below the floor must land on row 0
  assert_low_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && below_range) |=> (s1_idx == '0));

endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int DEPTH  = 72,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              waddr_ok;
  logic              raddr_ok;

  assign waddr_ok = int'(waddr) < DEPTH;
  assign raddr_ok = int'(raddr) < DEPTH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && waddr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = raddr_ok ? mem[raddr] : '0;

  // R6: the clamp upstream keeps every selected read inside this table
  assert_read_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(raddr) < DEPTH));

endmodule

// File: rtl/temp_lut_indexer.sv
module temp_lut_indexer #(
  parameter int TEMP_W       = 16,
  parameter int FRAC_W       = 8,
  parameter int BASE_C       = 40,
  parameter int FINE_SHIFT   = 1,
  parameter int COARSE_SHIFT = 2,
  parameter int FINE_DEPTH   = 72,
  parameter int COARSE_DEPTH = 36,
  parameter int DATA_W       = 8,
  localparam int MAX_DEPTH   = (FINE_DEPTH > COARSE_DEPTH) ? FINE_DEPTH : COARSE_DEPTH,
  localparam int IDX_W       = $clog2(MAX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              coarse_mode,
  input  logic              tbl_we,
  input  logic              tbl_coarse,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [DATA_W-1:0] tbl_wdata,
  output logic              lut_valid,
  output logic [IDX_W-1:0]  lut_index,
  output logic [DATA_W-1:0] lut_data
);

  localparam int N_TABLES = 2;

  logic              s1_valid;
  logic              s1_coarse;
  logic [IDX_W-1:0]  s1_idx;
  logic [DATA_W-1:0] rd_data [N_TABLES];
  logic [1:0]        since_rst;

  temp_index_calc #(
    .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .BASE_C(BASE_C),
    .FINE_SHIFT(FINE_SHIFT), .COARSE_SHIFT(COARSE_SHIFT),
    .FINE_DEPTH(FINE_DEPTH), .COARSE_DEPTH(COARSE_DEPTH), .IDX_W(IDX_W)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .temp_in(temp_in),
    .coarse_mode(coarse_mode), .s1_valid(s1_valid), .s1_coarse(s1_coarse),
    .s1_idx(s1_idx)
  );

  // Table 0 is the fine table, table 1 the coarse table.
  for (genvar g = 0; g < N_TABLES; g++) begin : g_tbl
    localparam int DEPTH_G = (g == 0) ? FINE_DEPTH : COARSE_DEPTH;
    logic we_g;
    logic rd_en_g;
    assign we_g    = tbl_we && (tbl_coarse == (g == 1));
    assign rd_en_g = s1_valid && (s1_coarse == (g == 1));
    lut_table #(.DEPTH(DEPTH_G), .DATA_W(DATA_W), .ADDR_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we(we_g), .waddr(tbl_addr),
      .wdata(tbl_wdata), .rd_en(rd_en_g), .raddr(s1_idx), .rdata(rd_data[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_valid <= 1'b0;
      lut_index <= '0;
      lut_data  <= '0;
    end else begin
      lut_valid <= s1_valid;
      if (s1_valid) begin
        lut_index <= s1_idx;
        lut_data  <= s1_coarse ? rd_data[1] : rd_data[0];
      end
    end
  end

  // Edge count since reset, for checks that look back in time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: the result strobe trails the sample strobe by two edges
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (lut_valid == $past(samp_valid, 2)));

  // R8: with no sample in flight the outputs hold
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(lut_data) && $stable(lut_index)));

  // R6: the coarse result never passes its last row
  assert_coarse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_coarse) |=> (int'(lut_index) < COARSE_DEPTH));

endmodule

// File: tb/temp_lut_indexer_bench.sv
`timescale 1ns/1ps
module temp_lut_indexer_bench;

  typedef struct {
    int    idx;
    int    data;
    int    cyc;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_valid = 1'b0;
  logic [15:0] temp_in = '0;
  logic       coarse_mode = 1'b0;
  logic       tbl_we = 1'b0;
  logic       tbl_coarse = 1'b0;
  logic [6:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic       lut_valid;
  logic [6:0] lut_index;
  logic [7:0] lut_data;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  bit   mon_on = 1'b0;
  exp_t q[$];
  logic [6:0] last_idx = '0;
  logic [7:0] last_data = '0;

  temp_lut_indexer u_temp_lut_indexer (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .temp_in(temp_in),
    .coarse_mode(coarse_mode), .tbl_we(tbl_we), .tbl_coarse(tbl_coarse),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .lut_valid(lut_valid),
    .lut_index(lut_index), .lut_data(lut_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected row: shift by 40 degrees, then whole steps of 2 or 4 degrees.
  function automatic int ref_index(int t, bit crs);
    int v, w, top;
    v   = t + 40 * 256;
    w   = crs ? 1024 : 512;
    top = crs ? 35 : 71;
    if (v < 0) return 0;
    if (v / w > top) return top;
    return v / w;
  endfunction

  function automatic int fine_val(int i);
    return (i * 7 + 3) % 256;
  endfunction

  function automatic int coarse_val(int i);
    return (200 - 3 * i) & 255;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Caller is at a falling edge.
  task automatic tbl_write(bit crs, int a, int d);
    tbl_we     = 1'b1;
    tbl_coarse = crs;
    tbl_addr   = 7'(a);
    tbl_wdata  = 8'(d);
    @(negedge clk);
    tbl_we     = 1'b0;
  endtask

  // Caller is at a falling edge; the mode flips after the strobe (R9).
  task automatic sample(bit crs, int t, string req);
    exp_t e;
    e.idx  = ref_index(t, crs);
    e.data = crs ? coarse_val(e.idx) : fine_val(e.idx);
    e.cyc  = cyc + 2;
    e.req  = req;
    q.push_back(e);
    samp_valid  = 1'b1;
    coarse_mode = crs;
    temp_in     = 16'(t);
    @(negedge clk);
    samp_valid  = 1'b0;
    coarse_mode = ~crs;
    temp_in     = 16'hA5A5;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (lut_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(lut_index) == e.idx, e.req, int'(lut_index), e.idx);
          chk(int'(lut_data) == e.data, "R7 data", int'(lut_data), e.data);
          chk(cyc == e.cyc, "R2 latency", cyc, e.cyc);
        end
        last_idx  = lut_index;
        last_data = lut_data;
      end else begin
        chk(lut_index == last_idx, "R8 index hold", int'(lut_index), int'(last_idx));
        chk(lut_data == last_data, "R8 data hold", int'(lut_data), int'(last_data));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lut_valid == 1'b0, "R1 valid", int'(lut_valid), 0);
    chk(lut_index == '0, "R1 index", int'(lut_index), 0);
    chk(lut_data == '0, "R1 data", int'(lut_data), 0);
    mon_on = 1'b1;

    // R10: load both tables, then try writes past each table's end
    for (int i = 0; i < 72; i++) tbl_write(1'b0, i, fine_val(i));
    for (int i = 0; i < 36; i++) tbl_write(1'b1, i, coarse_val(i));
    tbl_write(1'b0, 72, 8'hEE);
    tbl_write(1'b0, 127, 8'hEE);
    tbl_write(1'b1, 36, 8'hEE);
    tbl_write(1'b1, 100, 8'hEE);
    tbl_write(1'b1, 64, 8'hEE);
    repeat (2) @(negedge clk);

    sample(1'b0, 32767, "R10 fine last row after out-of-range writes");
    sample(1'b0, -10240, "R10 fine row 0 after out-of-range writes");
    sample(1'b1, 32767, "R10 coarse last row after out-of-range writes");
    sample(1'b1, -10240, "R10 coarse row 0 after out-of-range writes");
    repeat (3) @(negedge clk);

    // Fine boundaries
    sample(1'b0, -10240, "R3 fine exactly -40C");
    sample(1'b0, -9729, "R3 fine one LSB below -38C");
    sample(1'b0, -9728, "R3 fine exactly -38C");
    sample(1'b0, 6528, "R3 fine 25.5C");
    sample(1'b0, 26112, "R6 fine exactly +102C");
    sample(1'b0, 26623, "R6 fine just below +104C");
    sample(1'b0, 26624, "R6 fine +104C clamps");
    sample(1'b0, 32767, "R6 fine max code clamps");
    repeat (4) @(negedge clk);

    // Below-range in both modes
    sample(1'b0, -10241, "R5 fine one LSB below -40C");
    sample(1'b1, -10241, "R5 coarse one LSB below -40C");
    sample(1'b0, -32768, "R5 fine min code");
    sample(1'b1, -25600, "R5 coarse -100C");
    repeat (2) @(negedge clk);

    // Coarse boundaries
    sample(1'b1, -9217, "R4 coarse one LSB below -36C");
    sample(1'b1, -9216, "R4 coarse exactly -36C");
    sample(1'b1, 25599, "R4 coarse one LSB below +100C");
    sample(1'b1, 25600, "R6 coarse exactly +100C");
    sample(1'b1, 26624, "R6 coarse +104C clamps");
    sample(1'b1, 32512, "R6 coarse +127C clamps");
    repeat (3) @(negedge clk);

    // R9: modes alternating on consecutive cycles
    for (int k = 0; k < 10; k++)
      sample(1'(k % 2), -10240 + k * 2100, "R9 alternating modes");
    repeat (5) @(negedge clk);

    // Full sweeps with an offset inside each row
    for (int i = 0; i < 72; i++) begin
      sample(1'b0, -10240 + i * 512 + 100, "R3 fine sweep");
      if (i % 9 == 0) @(negedge clk);
    end
    for (int i = 0; i < 36; i++) begin
      sample(1'b1, -10240 + i * 1024 + 1023, "R4 coarse sweep");
      if (i % 5 == 0) repeat (2) @(negedge clk);
    end

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R2 all results delivered", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule